// File: doc/BRIEF.md
# Compare-Match Interval Timer Channel

The block is one timer channel with a small register set on a simple bus. A 32-bit counter advances on a count tick derived from a slow reference clock. The slow clock reaches the block as `ref_tick`, a pulse one system-clock cycle wide per slow-clock period. A three-bit select in the control/status register divides it by 1, 8, 32 or 128. Each time the counter passes the compare value, a match flag is set. In periodic mode the counter also restarts from zero, so each period lasts compare+1 ticks. An overflow flag records a wrap from all ones to zero that no match caused. The interrupt output follows the match flag when both the interrupt enable and the interrupt request type are selected.

Software runs or freezes the channel through one bit of a run-control register in the global space. The bit position is the parameter `CH_INDEX`. A counter write goes through a three-state load sequencer (`SY_IDLE`, `SY_ARM`, `SY_LOAD`). It reaches the counter only on the second slow-clock pulse after the write:
- `SY_IDLE -> SY_ARM` on a counter write.
- `SY_ARM -> SY_LOAD` on a slow-clock pulse.
- `SY_LOAD -> SY_IDLE` on the next pulse, which loads the counter.
- A new write in any state returns the sequencer to `SY_ARM` with the new value.

Bus map: with `glb_sel`=1, byte address 0x0 is the run-control register. With `glb_sel`=0, byte address 0x0 is control/status, 0x4 is the counter and 0x8 is the compare register. Each byte address is the word offset shifted left by 2.

Top module: `match_timer`

## Requirements
- R1: After reset, control/status reads 0, the counter reads 0, the compare register reads 0xFFFFFFFF, the run-control register reads 0 and `irq` is 0.
- R2: The counter advances only while bit `CH_INDEX` (0 by default) of the run-control register is 1. Clearing that bit freezes the counter at its value. Other bits of that register are ignored and read back as 0.
- R3: Control/status bit 15 (match) and bit 14 (overflow) are cleared by writing 0 to them. Writing 1 leaves them unchanged.
- R4: With control/status bit 8 = 1, a count tick that finds the counter equal to compare loads 0 and sets bit 15, so each period is compare+1 ticks.
- R5: With bit 8 = 0, the counter does not clear on a match. It goes on to compare+1, and bit 15 is still set.
- R6: `irq` is 1 exactly when bit 15, bit 7 (interrupt enable) and bits 5:4 = 2 (interrupt request) are all set. It stays 1 until software clears bit 15 or changes those fields.
- R7: Control/status bits 2:0 select the count tick. Code 7 counts every slow pulse, and codes 4, 5 and 6 count every 8th, 32nd and 128th pulse. Codes 0 to 3 give no count.
- R8: A counter write is invisible to reads and to the compare logic until the second slow-clock pulse after it, when the counter takes the written value.
- R9: A count tick that takes the counter from 0xFFFFFFFF to 0 without a compare match sets bit 14.
- R10: When a hardware set of the match flag and a software clear of it fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse per slow reference clock period |
| glb_sel | input | 1 | 1 selects the global space, 0 the channel registers |
| bus_addr | input | 4 | Byte address inside the selected space |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Match interrupt, level |

## Verification
The assertions check the following on every cycle:
- no count tick occurs while the channel is stopped;
- the counter holds still unless a tick or a delayed load occurs;
- a counter write never moves the counter in the cycle it is issued;
- a periodic match returns the counter to zero and sets the match flag;
- the interrupt has its flag behind it and holds until a register write.

The following can only be shown by the bench's scenarios, because each spans many slow-clock pulses:
- the divide ratios of the clock-select codes;
- the two-pulse delay seen at the read port;
- the overflow wrap from all ones;
- the same-cycle race between a set and a clear of the match flag.

// File: rtl/mtmr_pkg.sv
`timescale 1ns/1ps
package mtmr_pkg;

    localparam int CNT_W  = 32;
    localparam int CTL_W  = 32;
    localparam int ADDR_W = 4;

    // channel register byte addresses (word offset << 2)
    localparam logic [ADDR_W-1:0] A_CSR = 4'h0;
    localparam logic [ADDR_W-1:0] A_CNT = 4'h4;
    localparam logic [ADDR_W-1:0] A_COR = 4'h8;
    localparam logic [ADDR_W-1:0] A_RUN = 4'h0;

    // control/status bit positions
    localparam int B_MF   = 15;
    localparam int B_OVF  = 14;
    localparam int B_MODE = 8;
    localparam int B_IE   = 7;
    localparam int B_REQ  = 4;
    localparam int B_CKS  = 0;

    localparam logic [1:0] REQ_IRQ = 2'd2;

    typedef enum logic [2:0] {
        CK_OFF0 = 3'd0,
        CK_OFF1 = 3'd1,
        CK_OFF2 = 3'd2,
        CK_OFF3 = 3'd3,
        CK_D8   = 3'd4,
        CK_D32  = 3'd5,
        CK_D128 = 3'd6,
        CK_D1   = 3'd7
    } cksel_e;

    typedef enum logic [1:0] {
        SY_IDLE = 2'd0,
        SY_ARM  = 2'd1,
        SY_LOAD = 2'd2
    } sync_e;

endpackage

// File: rtl/mtmr_prescaler.sv
`timescale 1ns/1ps
module mtmr_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       ref_tick,
    input  logic [2:0] cks,
    output logic       cnt_tick
);
    import mtmr_pkg::*;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;
    logic             sel_on;

    always_comb begin
        lim    = '0;
        sel_on = 1'b1;
        unique case (cksel_e'(cks))
            CK_D1:   lim = PRE_W'(0);
            CK_D8:   lim = PRE_W'(7);
            CK_D32:  lim = PRE_W'(31);
            CK_D128: lim = PRE_W'(127);
            default: sel_on = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (!run || !sel_on)
            pre_q <= '0;
        else if (ref_tick)
            pre_q <= (pre_q >= lim) ? '0 : pre_q + 1'b1;
    end

    assign cnt_tick = run && sel_on && ref_tick && (pre_q >= lim);

endmodule

// File: rtl/mtmr_wr_sync.sv
`timescale 1ns/1ps
module mtmr_wr_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ref_tick,
    output logic         apply,
    output logic [W-1:0] apply_val
);
    import mtmr_pkg::*;

    sync_e        st_q, st_d;
    logic [W-1:0] hold_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SY_IDLE: if (wr) st_d = SY_ARM;
            SY_ARM:  if (wr) st_d = SY_ARM;
                     else if (ref_tick) st_d = SY_LOAD;
            SY_LOAD: if (wr) st_d = SY_ARM;
                     else if (ref_tick) st_d = SY_IDLE;
            default: st_d = SY_IDLE;
        endcase
    end

    // state register and held value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SY_IDLE;
            hold_q <= '0;
        end else begin
            st_q <= st_d;
            if (wr) hold_q <= wdata;
        end
    end

    // outputs
    always_comb begin
        apply     = 1'b0;
        apply_val = hold_q;
        unique case (st_q)
            SY_LOAD: apply = ref_tick && !wr;
            default: apply = 1'b0;
        endcase
    end

endmodule

// File: rtl/mtmr_core.sv
`timescale 1ns/1ps
module mtmr_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         apply,
    input  logic [W-1:0] apply_val,
    input  logic [W-1:0] cor,
    input  logic         periodic,
    input  logic         flag_wr,
    input  logic         keep_mf,
    input  logic         keep_ovf,
    output logic [W-1:0] cnt,
    output logic         mf,
    output logic         ovf
);
    logic [W-1:0] cnt_q;
    logic         mf_q, ovf_q;
    logic         hit, top, mf_set, ovf_set;

    assign hit     = (cnt_q == cor);
    assign top     = &cnt_q;
    assign mf_set  = tick && hit;
    assign ovf_set = tick && top && !hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (apply)
            cnt_q <= apply_val;
        else if (tick)
            cnt_q <= (periodic && hit) ? '0 : cnt_q + 1'b1;
    end

    // hardware set has priority over a software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mf_q  <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            mf_q  <= mf_set  || (mf_q  && !(flag_wr && !keep_mf));
            ovf_q <= ovf_set || (ovf_q && !(flag_wr && !keep_ovf));
        end
    end

    assign cnt = cnt_q;
    assign mf  = mf_q;
    assign ovf = ovf_q;

endmodule

// File: rtl/match_timer.sv
`timescale 1ns/1ps
module match_timer #(
    parameter int CH_INDEX = 0,
    parameter int PRE_W    = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ref_tick,
    input  logic                      glb_sel,
    input  logic [mtmr_pkg::ADDR_W-1:0] bus_addr,
    input  logic                      bus_wr,
    input  logic [mtmr_pkg::CTL_W-1:0] bus_wdata,
    output logic [mtmr_pkg::CTL_W-1:0] bus_rdata,
    output logic                      irq
);
    import mtmr_pkg::*;

    localparam logic [CNT_W-1:0] COR_RST = {CNT_W{1'b1}};

    logic             run_q;
    logic             mode_q, ie_q;
    logic [1:0]       req_q;
    logic [2:0]       cks_q;
    logic [CNT_W-1:0] cor_q;

    logic             wr_run, wr_csr, wr_cnt, wr_cor;
    logic             tick, apply;
    logic [CNT_W-1:0] apply_val, cnt;
    logic             mf, ovf;

    assign wr_run = bus_wr &&  glb_sel && (bus_addr == A_RUN);
    assign wr_csr = bus_wr && !glb_sel && (bus_addr == A_CSR);
    assign wr_cnt = bus_wr && !glb_sel && (bus_addr == A_CNT);
    assign wr_cor = bus_wr && !glb_sel && (bus_addr == A_COR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= 1'b0;
            ie_q   <= 1'b0;
            req_q  <= '0;
            cks_q  <= '0;
            cor_q  <= COR_RST;
        end else begin
            if (wr_run) run_q <= bus_wdata[CH_INDEX];
            if (wr_csr) begin
                mode_q <= bus_wdata[B_MODE];
                ie_q   <= bus_wdata[B_IE];
                req_q  <= bus_wdata[B_REQ +: 2];
                cks_q  <= bus_wdata[B_CKS +: 3];
            end
            if (wr_cor) cor_q <= bus_wdata[CNT_W-1:0];
        end
    end

    mtmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .ref_tick (ref_tick),
        .cks      (cks_q),
        .cnt_tick (tick)
    );

    mtmr_wr_sync #(.W(CNT_W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_cnt),
        .wdata     (bus_wdata[CNT_W-1:0]),
        .ref_tick  (ref_tick),
        .apply     (apply),
        .apply_val (apply_val)
    );

    mtmr_core #(.W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .apply     (apply),
        .apply_val (apply_val),
        .cor       (cor_q),
        .periodic  (mode_q),
        .flag_wr   (wr_csr),
        .keep_mf   (bus_wdata[B_MF]),
        .keep_ovf  (bus_wdata[B_OVF]),
        .cnt       (cnt),
        .mf        (mf),
        .ovf       (ovf)
    );

    always_comb begin
        bus_rdata = '0;
        if (glb_sel) begin
            if (bus_addr == A_RUN) bus_rdata[CH_INDEX] = run_q;
        end else begin
            unique case (bus_addr)
                A_CSR: begin
                    bus_rdata[B_MF]       = mf;
                    bus_rdata[B_OVF]      = ovf;
                    bus_rdata[B_MODE]     = mode_q;
                    bus_rdata[B_IE]       = ie_q;
                    bus_rdata[B_REQ +: 2] = req_q;
                    bus_rdata[B_CKS +: 3] = cks_q;
                end
                A_CNT:   bus_rdata[CNT_W-1:0] = cnt;
                A_COR:   bus_rdata[CNT_W-1:0] = cor_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq = mf && ie_q && (req_q == REQ_IRQ);

endmodule

// File: rtl/match_timer_chk.sv
`timescale 1ns/1ps
module match_timer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         tick,
    input logic         apply,
    input logic         wr_cnt,
    input logic         wr_csr,
    input logic         periodic,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cor,
    input logic         mf,
    input logic         irq
);
    // R2: a stopped channel produces no count tick
    a_r2_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

    // R2: the counter only moves on a tick or a delayed load
    a_r2_cnt_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !apply) |=> $stable(cnt));

    // R8: a counter write does not reach the counter in its own cycle
    a_r8_no_early_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && !tick && !apply) |=> $stable(cnt));

    // R4: periodic match returns to zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && periodic && (cnt == cor) && !apply) |=> (cnt == '0));

    // R10: the match flag is set after a matching tick, whatever the bus did
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt == cor)) |=> mf);

    // R6: interrupt needs the flag and holds without a control write
    a_r6_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mf);
    a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_csr) |=> irq);
endmodule

bind match_timer match_timer_chk #(.W(mtmr_pkg::CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .tick     (tick),
    .apply    (apply),
    .wr_cnt   (wr_cnt),
    .wr_csr   (wr_csr),
    .periodic (mode_q),
    .cnt      (cnt),
    .cor      (cor_q),
    .mf       (mf),
    .irq      (irq)
);

// File: tb/match_timer_tb_top.sv
`timescale 1ns/1ps
module match_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        glb_sel = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    match_timer dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .glb_sel(glb_sel),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // vector: {cks[2:0], pulses[15:0], expected count[31:0]}  (R7)
    localparam logic [50:0] VEC [6] = '{
        {3'd7, 16'd10,  32'd10},
        {3'd4, 16'd20,  32'd2},
        {3'd5, 16'd70,  32'd2},
        {3'd6, 16'd300, 32'd2},
        {3'd0, 16'd20,  32'd0},
        {3'd3, 16'd9,   32'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic g, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        glb_sel = g; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic g, input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        glb_sel = g; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
    endtask

    task automatic load_cnt(input logic [31:0] v);
        wr(1'b0, 4'h4, v);
        pulses(2);
    endtask

    logic [31:0] r;
    bit done = 1'b0;

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, 4'h0, r); check("R1 csr", r, 32'h0);
        rd(1'b0, 4'h4, r); check("R1 cnt", r, 32'h0);
        rd(1'b0, 4'h8, r); check("R1 cor", r, 32'hFFFF_FFFF);
        rd(1'b1, 4'h0, r); check("R1 run", r, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R7 clock select table
        for (int v = 0; v < 6; v++) begin
            wr(1'b1, 4'h0, 32'h0);
            wr(1'b0, 4'h0, {29'd0, VEC[v][50:48]});
            load_cnt(32'h0);
            wr(1'b1, 4'h0, 32'h1);
            pulses(int'(VEC[v][47:32]));
            rd(1'b0, 4'h4, r);
            check("R7 prescale", r, VEC[v][31:0]);
        end

        // R4 periodic
        wr(1'b1, 4'h0, 32'h0);
        wr(1'b0, 4'h0, 32'h0107);
        wr(1'b0, 4'h8, 32'd3);
        load_cnt(32'h0);
        wr(1'b1, 4'h0, 32'h1);
        pulses(3);
        rd(1'b0, 4'h4, r); check("R4 before match cnt", r, 32'd3);
        rd(1'b0, 4'h0, r); check("R4 before match flag", r, 32'h0107);
        pulses(1);
        rd(1'b0, 4'h4, r); check("R4 wrap cnt", r, 32'd0);
        rd(1'b0, 4'h0, r); check("R4 flag set", r, 32'h8107);
        wr(1'b1, 4'h0, 32'h0);

        // R6 interrupt, R3 clear semantics
        wr(1'b0, 4'h0, 32'hC1A7);
        check("R6 irq on", {31'd0, irq}, 32'd1);
        wr(1'b0, 4'h0, 32'hC187);
        check("R6 irq off req0", {31'd0, irq}, 32'd0);
        wr(1'b0, 4'h0, 32'hC1A7);
        check("R3 keep by 1", {31'd0, irq}, 32'd1);
        wr(1'b0, 4'h0, 32'h41A7);
        check("R3 clear irq", {31'd0, irq}, 32'd0);
        rd(1'b0, 4'h0, r); check("R3 cleared csr", r, 32'h01A7);

        // R5 free running
        wr(1'b0, 4'h0, 32'h0007);
        wr(1'b0, 4'h8, 32'd3);
        load_cnt(32'h0);
        wr(1'b1, 4'h0, 32'h1);
        pulses(4);
        rd(1'b0, 4'h4, r); check("R5 no clear", r, 32'd4);
        rd(1'b0, 4'h0, r); check("R5 flag", r, 32'h8007);

        // R9 overflow
        wr(1'b1, 4'h0, 32'h0);
        wr(1'b0, 4'h0, 32'h0007);
        wr(1'b0, 4'h8, 32'd5);
        load_cnt(32'hFFFF_FFFE);
        wr(1'b1, 4'h0, 32'h1);
        pulses(2);
        rd(1'b0, 4'h4, r); check("R9 wrap cnt", r, 32'd0);
        rd(1'b0, 4'h0, r); check("R9 ovf flag", r, 32'h4007);

        // R2 freeze and ignored run bits
        wr(1'b1, 4'h0, 32'h0);
        pulses(3);
        rd(1'b0, 4'h4, r); check("R2 frozen", r, 32'd0);
        wr(1'b1, 4'h0, 32'h2);
        pulses(2);
        rd(1'b0, 4'h4, r); check("R2 other bit", r, 32'd0);
        rd(1'b1, 4'h0, r); check("R2 run readback", r, 32'd0);
        wr(1'b1, 4'h0, 32'h1);
        pulses(1);
        rd(1'b0, 4'h4, r); check("R2 resumes", r, 32'd1);

        // R8 delayed counter write
        wr(1'b1, 4'h0, 32'h0);
        wr(1'b0, 4'h4, 32'h55);
        rd(1'b0, 4'h4, r); check("R8 no pulse", r, 32'd1);
        pulses(1);
        rd(1'b0, 4'h4, r); check("R8 one pulse", r, 32'd1);
        pulses(1);
        rd(1'b0, 4'h4, r); check("R8 two pulses", r, 32'h55);

        // R10 set beats clear in the same cycle
        wr(1'b0, 4'h0, 32'h0107);
        wr(1'b0, 4'h8, 32'd0);
        load_cnt(32'h0);
        wr(1'b1, 4'h0, 32'h1);
        pulses(1);
        rd(1'b0, 4'h0, r); check("R10 flag set", r, 32'h8107);
        @(negedge clk);
        glb_sel = 1'b0; bus_addr = 4'h0; bus_wdata = 32'h4107;
        bus_wr = 1'b1; ref_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ref_tick = 1'b0;
        rd(1'b0, 4'h0, r); check("R10 set wins", r, 32'h8107);
        wr(1'b1, 4'h0, 32'h0);
        wr(1'b0, 4'h0, 32'h4107);
        rd(1'b0, 4'h0, r); check("R3 plain clear", r, 32'h0107);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule